// File: doc/BRIEF.md
# Counter-array timebase

This block is the shared 16-bit timebase behind a set of capture/compare channels. It holds an up-counter that advances by one on each count pulse. A software-written select picks the pulse from four sources: a slow internal prescale of the clock, a fast internal prescale of the clock, the overflow strobe of a neighbouring timer, or an external pin. A double-speed input halves both internal prescale ratios. The external pin is synchronised and its rising edges are counted. All logic runs on one clock.

Software controls the block through a small byte bus with four addresses: a mode register, a control register, and the low and high count bytes. Counting needs the run bit. As an option, counting can also pause while the chip-level idle input is high. When the count wraps from all ones to zero, the block sets a sticky overflow flag and sends a one-cycle overflow pulse to the attached channels. An interrupt request follows the flag when the interrupt enable in the mode register is set. A watchdog-enable bit for one of the channels is stored and brought out as a port. The watchdog itself lives in that channel.

Top module: `pca_timebase`

## Requirements
- R1: With select 00 (mode bits 2:1), the count advances once every 12 clock cycles, or once every 6 when `x2_mode` is high.
- R2: With select 01, the count advances once every 4 clock cycles, or once every 2 when `x2_mode` is high.
- R3: With select 10, the count advances by one for every clock cycle in which `t0_ovf` is high, including back-to-back cycles.
- R4: With select 11, each rising edge on `ext_pin` advances the count by exactly one. The step lands on the third rising clock edge, counting the first edge that samples the pin high as the first. A pin held high does not count again.
- R5: The count holds while the run bit (control register bit 0) is 0.
- R6: When mode bit 7 is 1 and `idle` is high, the count holds. When mode bit 7 is 0, the count keeps advancing during `idle`.
- R7: On the step from 0xFFFF to 0x0000, the overflow flag (control bit 7, port `ovf_flag`) is set, and `ovf_pulse` is high for exactly the one cycle in which the count reads 0.
- R8: The overflow flag stays set until software writes 0 to control bit 7. If a wrap and such a write fall in the same cycle, the flag ends up set.
- R9: `irq` equals the overflow flag ANDed with mode bit 0. With mode bit 0 cleared, a set flag raises no request.
- R10: The mode register (address 0) holds idle gating in bit 7, watchdog enable in bit 6, the source select in bits 2:1 and the interrupt enable in bit 0. It resets to 0, and bits 5:3 read as 0. `wdog_en` mirrors bit 6.
- R11: The count low byte (address 2) and high byte (address 3) can be read and written. A byte write in a cycle that also has a count pulse stores the written value, and the count does not advance in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 mode, 1 control, 2 count low, 3 count high |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| x2_mode | input | 1 | Halves the internal prescale ratios |
| idle | input | 1 | Chip idle indication |
| t0_ovf | input | 1 | Overflow strobe of the neighbouring timer |
| ext_pin | input | 1 | Asynchronous external count input |
| count | output | 16 | Current count value |
| ovf_pulse | output | 1 | One-cycle wrap pulse to the attached channels |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |
| wdog_en | output | 1 | Stored watchdog enable for the attached channel |

## Verification
The case that is hardest to reach is a hardware flag set that coincides with a software clear. A wrap only happens on one exact cycle, so the bench switches to the neighbour-timer source, writes 0xFFFF into the count and then asserts `t0_ovf` in the same cycle as the control write that clears the flag. The same method places a count pulse on the cycle of a count-byte write. The prescaled sources have no fixed phase after a select change, so the bench measures the gap between successive count steps and does not rely on absolute cycle numbers.

// File: rtl/pca_timebase_pkg.sv
package pca_timebase_pkg;
  typedef enum logic [1:0] {
    SRC_DIV_SLOW = 2'b00,
    SRC_DIV_FAST = 2'b01,
    SRC_TIMER    = 2'b10,
    SRC_PIN      = 2'b11
  } src_e;

  localparam logic [1:0] ADDR_MODE   = 2'd0;
  localparam logic [1:0] ADDR_CTRL   = 2'd1;
  localparam logic [1:0] ADDR_CNT_LO = 2'd2;
  localparam logic [1:0] ADDR_CNT_HI = 2'd3;

  // Prescale ratio for an internal source; double-speed mode halves it.
  function automatic int unsigned div_of(src_e s, logic x2,
                                         int unsigned slow, int unsigned fast);
    int unsigned d;
    d = (s == SRC_DIV_SLOW) ? slow : fast;
    return x2 ? (d / 2) : d;
  endfunction

  // Mode register image with reserved bits forced to zero.
  function automatic logic [7:0] mode_image(logic idle_gate, logic wd, src_e s, logic ie);
    return {idle_gate, wd, 3'b000, s, ie};
  endfunction
endpackage

// File: rtl/pca_prescaler.sv
module pca_prescaler
  import pca_timebase_pkg::*;
#(
  parameter int unsigned SLOW_DIV = 12,
  parameter int unsigned FAST_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  src_e src,
  input  logic x2,
  output logic tick
);
  localparam int PW = $clog2(SLOW_DIV + 1);

  logic [PW-1:0] cnt;
  logic [PW-1:0] reload;
  src_e          src_q;
  logic          sel_chg;

  assign sel_chg = (src != src_q);
  assign reload  = PW'(div_of(src, x2, SLOW_DIV, FAST_DIV));
  assign tick    = !sel_chg && (cnt == PW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= PW'(SLOW_DIV);
      src_q <= SRC_DIV_SLOW;
    end else begin
      src_q <= src;
      if (sel_chg || cnt <= PW'(1)) cnt <= reload;
      else                          cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/pca_edge_sync.sv
module pca_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], pin};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/pca_count.sv
module pca_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [7:0]       wdata,
  output logic [CNT_W-1:0] value,
  output logic             wrap
);
  localparam int HI_W = CNT_W - 8;

  logic any_wr;
  assign any_wr = wr_lo | wr_hi;
  assign wrap   = en & ~any_wr & (&value);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (any_wr) begin
      if (wr_lo) value[7:0]       <= wdata;
      if (wr_hi) value[CNT_W-1:8] <= wdata[HI_W-1:0];
    end else if (en) begin
      value <= value + 1'b1;
    end
  end
endmodule

// File: rtl/pca_timebase.sv
module pca_timebase
  import pca_timebase_pkg::*;
#(
  parameter int          CNT_W       = 16,
  parameter int unsigned SLOW_DIV    = 12,
  parameter int unsigned FAST_DIV    = 4,
  parameter int          SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             x2_mode,
  input  logic             idle,
  input  logic             t0_ovf,
  input  logic             ext_pin,
  output logic [CNT_W-1:0] count,
  output logic             ovf_pulse,
  output logic             ovf_flag,
  output logic             irq,
  output logic             wdog_en
);
  // Mode and control state
  logic idle_ctl, ecf, run;
  src_e src;

  // Named internal events
  logic wr_mode, wr_ctrl, wr_lo, wr_hi, count_wr;
  logic div_tick, pin_rise, src_tick, cnt_en, wrap;

  assign wr_mode  = bus_wr && (bus_addr == ADDR_MODE);
  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_lo    = bus_wr && (bus_addr == ADDR_CNT_LO);
  assign wr_hi    = bus_wr && (bus_addr == ADDR_CNT_HI);
  assign count_wr = wr_lo | wr_hi;

  pca_prescaler #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .src(src), .x2(x2_mode), .tick(div_tick)
  );

  pca_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .rise(pin_rise)
  );

  always_comb begin
    unique case (src)
      SRC_DIV_SLOW, SRC_DIV_FAST: src_tick = div_tick;
      SRC_TIMER:                  src_tick = t0_ovf;
      default:                    src_tick = pin_rise;
    endcase
  end

  assign cnt_en = run & ~(idle & idle_ctl) & src_tick;

  pca_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(cnt_en), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wdata(bus_wdata), .value(count), .wrap(wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_ctl  <= 1'b0;
      wdog_en   <= 1'b0;
      src       <= SRC_DIV_SLOW;
      ecf       <= 1'b0;
      run       <= 1'b0;
      ovf_flag  <= 1'b0;
      ovf_pulse <= 1'b0;
    end else begin
      ovf_pulse <= wrap;
      if (wr_mode) begin
        idle_ctl <= bus_wdata[7];
        wdog_en  <= bus_wdata[6];
        src      <= src_e'(bus_wdata[2:1]);
        ecf      <= bus_wdata[0];
      end
      if (wr_ctrl) run <= bus_wdata[0];
      if (wrap)         ovf_flag <= 1'b1;
      else if (wr_ctrl) ovf_flag <= bus_wdata[7];
    end
  end

  assign irq = ovf_flag & ecf;

  always_comb begin
    unique case (bus_addr)
      ADDR_MODE:   bus_rdata = mode_image(idle_ctl, wdog_en, src, ecf);
      ADDR_CTRL:   bus_rdata = {ovf_flag, 6'b000000, run};
      ADDR_CNT_LO: bus_rdata = count[7:0];
      default:     bus_rdata = count[15:8];
    endcase
  end
endmodule

// File: rtl/pca_timebase_chk.sv
module pca_timebase_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count,
  input logic             ovf_pulse,
  input logic             ovf_flag,
  input logic             irq,
  input logic             run,
  input logic             idle,
  input logic             idle_ctl,
  input logic             count_wr
);
  AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> (count == '0)); // R7
  AST_OVF_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> ovf_flag); // R7
  AST_OVF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse); // R7
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ovf_flag); // R9
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !count_wr) |=> $stable(count)); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && idle_ctl && !count_wr) |=> $stable(count)); // R6
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !count_wr |=> (count == $past(count) || count == CNT_W'($past(count) + 1'b1))); // R1
endmodule

bind pca_timebase pca_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .count(count), .ovf_pulse(ovf_pulse),
  .ovf_flag(ovf_flag), .irq(irq), .run(run), .idle(idle),
  .idle_ctl(idle_ctl), .count_wr(count_wr)
);

// File: tb/pca_timebase_bench.sv
`timescale 1ns/100ps
module pca_timebase_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = 8'd0;
  logic [7:0]  bus_rdata;
  logic        x2_mode = 1'b0, idle = 1'b0, t0_ovf = 1'b0, ext_pin = 1'b0;
  logic [15:0] count;
  logic        ovf_pulse, ovf_flag, irq, wdog_en;

  int checks = 0;
  int errors = 0;
  int meas = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pca_timebase u_pca_timebase (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .x2_mode(x2_mode),
    .idle(idle), .t0_ovf(t0_ovf), .ext_pin(ext_pin), .count(count),
    .ovf_pulse(ovf_pulse), .ovf_flag(ovf_flag), .irq(irq), .wdog_en(wdog_en)
  );

  // Scoreboard items: kind 0 rdata, 1 count, 2 ovf_pulse, 3 ovf_flag,
  // 4 irq, 5 wdog_en, 6 measured step interval
  typedef struct {
    string       tag;
    int          kind;
    logic [15:0] exp;
  } item_t;
  item_t exp_q[$];

  always @(negedge clk) begin
    item_t it;
    logic [15:0] act;
    while (exp_q.size() > 0) begin
      it = exp_q.pop_front();
      case (it.kind)
        0: act = {8'h00, bus_rdata};
        1: act = count;
        2: act = {15'd0, ovf_pulse};
        3: act = {15'd0, ovf_flag};
        4: act = {15'd0, irq};
        5: act = {15'd0, wdog_en};
        default: act = 16'(meas);
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %0h expected %0h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_item(int kind, logic [15:0] exp, string tag);
    item_t it;
    it.tag = tag; it.kind = kind; it.exp = exp;
    exp_q.push_back(it);
  endtask

  task automatic expect_rd(logic [1:0] a, logic [7:0] exp, string tag);
    bus_addr = a;
    expect_item(0, {8'h00, exp}, tag);
  endtask

  task automatic sample();
    @(negedge clk); #1;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d, bit pulse = 0);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; t0_ovf = pulse;
    @(posedge clk); #1;
    bus_wr = 1'b0; t0_ovf = 1'b0;
  endtask

  task automatic t0_burst(int len);
    @(posedge clk); #1;
    t0_ovf = 1'b1;
    repeat (len) @(posedge clk);
    #1 t0_ovf = 1'b0;
  endtask

  task automatic measure();
    logic [15:0] last;
    int n;
    @(negedge clk); last = count;
    for (int i = 0; i < 100 && count == last; i++) @(negedge clk);
    last = count; n = 0;
    for (int i = 0; i < 100 && count == last; i++) begin
      @(negedge clk); n++;
    end
    meas = n;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] base;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10 reset state
    expect_rd(2'd0, 8'h00, "R10 mode reset"); sample();
    expect_rd(2'd1, 8'h00, "R10 control reset"); sample();
    expect_item(1, 16'h0000, "R11 count reset");
    expect_item(5, 16'd0, "R10 wdog_en reset");
    expect_item(4, 16'd0, "R9 irq reset"); sample();

    // R10 reserved bits read zero, wdog_en follows bit 6
    wr(2'd0, 8'hFF);
    expect_rd(2'd0, 8'hC7, "R10 reserved bits zero");
    expect_item(5, 16'd1, "R10 wdog_en set"); sample();

    // R11 byte access
    wr(2'd0, 8'h04);
    wr(2'd2, 8'h34);
    wr(2'd3, 8'h12);
    expect_rd(2'd2, 8'h34, "R11 low byte");
    expect_item(1, 16'h1234, "R11 count port"); sample();
    expect_rd(2'd3, 8'h12, "R11 high byte"); sample();

    // R5 stopped counter ignores pulses
    t0_burst(3);
    expect_item(1, 16'h1234, "R5 run clear holds"); sample();

    // R3 neighbour-timer pulses, single and back to back
    wr(2'd1, 8'h01);
    t0_burst(1); t0_burst(1); t0_burst(3);
    expect_item(1, 16'h1239, "R3 timer pulses"); sample();

    // R6 idle gating
    wr(2'd0, 8'h84);
    idle = 1'b1;
    t0_burst(4);
    expect_item(1, 16'h1239, "R6 gated in idle"); sample();
    wr(2'd0, 8'h04);
    t0_burst(2);
    expect_item(1, 16'h123B, "R6 counts in idle without gating"); sample();
    idle = 1'b0;

    // R1 slow prescale
    wr(2'd0, 8'h00);
    measure(); expect_item(6, 16'd12, "R1 slow period"); sample();
    x2_mode = 1'b1;
    measure(); expect_item(6, 16'd6, "R1 slow period x2"); sample();

    // R2 fast prescale
    wr(2'd0, 8'h02);
    measure(); expect_item(6, 16'd2, "R2 fast period x2"); sample();
    x2_mode = 1'b0;
    measure(); expect_item(6, 16'd4, "R2 fast period"); sample();

    // R4 external pin: latency and single count for a held level
    wr(2'd0, 8'h06);
    wr(2'd2, 8'h00); wr(2'd3, 8'h00);
    @(posedge clk); #1 ext_pin = 1'b1;
    expect_item(1, 16'h0000, "R4 before first sampling edge"); sample();
    expect_item(1, 16'h0000, "R4 after edge 1"); sample();
    expect_item(1, 16'h0000, "R4 after edge 2"); sample();
    expect_item(1, 16'h0001, "R4 step on edge 3"); sample();
    repeat (8) @(posedge clk);
    expect_item(1, 16'h0001, "R4 held level counts once"); sample();
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1 ext_pin = 1'b0;
      repeat (4) @(posedge clk);
      #1 ext_pin = 1'b1;
      repeat (4) @(posedge clk);
    end
    #1;
    expect_item(1, 16'h0004, "R4 three more edges"); sample();
    ext_pin = 1'b0;

    // R7 wrap
    wr(2'd0, 8'h04);
    wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
    @(posedge clk); #1 t0_ovf = 1'b1;
    @(posedge clk); #1 t0_ovf = 1'b0;
    expect_item(1, 16'h0000, "R7 count wraps to zero");
    expect_item(2, 16'd1, "R7 overflow pulse");
    expect_item(3, 16'd1, "R7 flag set");
    expect_item(4, 16'd0, "R9 no irq while disabled");
    expect_rd(2'd1, 8'h81, "R7 flag in control bit 7"); sample();
    expect_item(2, 16'd0, "R7 pulse one cycle"); sample();

    // R9 interrupt enable
    wr(2'd0, 8'h05);
    expect_item(4, 16'd1, "R9 irq with enable"); sample();

    // R8 sticky then cleared by software
    repeat (10) @(posedge clk);
    #1;
    expect_item(3, 16'd1, "R8 flag sticky"); sample();
    wr(2'd1, 8'h01);
    expect_item(3, 16'd0, "R8 software clear");
    expect_item(4, 16'd0, "R9 irq drops with flag"); sample();

    // R8 hardware set beats same-cycle software clear
    wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
    wr(2'd1, 8'h01, 1'b1);
    expect_rd(2'd1, 8'h81, "R8 set wins over clear");
    expect_item(1, 16'h0000, "R8 wrap in clear cycle"); sample();

    // R11 byte write beats same-cycle count pulse
    wr(2'd2, 8'h10); wr(2'd3, 8'h00);
    wr(2'd2, 8'h55, 1'b1);
    expect_item(1, 16'h0055, "R11 write beats increment"); sample();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule